// File: doc/BRIEF.md
# Morse SOS Beacon Controller

This block drives one lamp bit that spells the Morse distress call SOS over and over, with every duration counted in clock cycles. A dot lights the lamp for a short interval and a dash for a long one. Each letter is three equal flashes. Gaps between flashes, between letters and after the whole word each have their own length.

Inside the block, a word-level state machine tracks which letter is being sent. A letter-level state machine produces the three flashes of that letter and the gaps after them. Both share one reloadable down-counter. The letter machine picks one of four durations for the counter and reloads it each time the count runs out.

The only inputs are the clock and a synchronous reset. Besides the lamp, the block exposes the index of the current letter so that the sequence can be observed. With the default lengths, one full repetition lasts 37 cycles: 30 cycles of message followed by the closing gap.

Top module: `sos_beacon`

## Requirements
- R1: Each flash of the first and last letter (char_idx 0 and 2) is a dot: the lamp is high for exactly SHORT_LEN cycles (default 1).
- R2: Each flash of the middle letter (char_idx 1) is a dash: the lamp is high for exactly DASH_LEN cycles (default 4).
- R3: Letters are sent in the order char_idx 0 (S), 1 (O), 2 (S), then back to 0. char_idx never takes the value 3. char_idx takes its new value on the first lamp-high cycle of a letter and holds it through the gap that follows that letter.
- R4: Between two flashes of the same letter, the lamp is low for exactly SHORT_LEN cycles (default 1).
- R5: Between the last flash of one letter and the first flash of the next letter in the same word, the lamp is low for exactly CHAR_GAP cycles (default 3).
- R6: After the last flash of the final S, the lamp is low for exactly MSG_GAP cycles (default 7), in place of the letter gap. The word then restarts, so the default period is 37 cycles.
- R7: The shared counter, once loaded with a duration, decrements once per cycle and signals expiry on the last cycle of that duration. Every lamp-high or lamp-low interval lasts exactly the selected duration.
- R8: While rst is high, lamp is 0 and char_idx is 0. In the first cycle after rst falls, the lamp is high as the first dot of the first S, with no leading gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lamp | output | 1 | Lamp drive, high while a flash is lit |
| char_idx | output | 2 | Letter in progress: 0 first S, 1 O, 2 last S |

## Verification
The bench compares the lamp and the letter index against the expected pattern on every cycle for three full repetitions. This catches a design that adds the letter gap to the closing gap, which would give a 10-cycle tail and a 40-cycle period. It also catches a design that reuses the dot length for the dashes of O, or that steps char_idx at the start of a gap instead of at the next flash. A reset applied in the middle of a dash must drop the lamp at once and restart with a single dot. A design that inserts a leading gap after reset, or that resumes the interrupted dash, would show a low lamp, or a lamp that stays high, at the first cycles after release.

// File: rtl/sos_beacon.sv
module sos_beacon #(
  parameter int SHORT_LEN = 1,
  parameter int DASH_LEN  = 4,
  parameter int CHAR_GAP  = 3,
  parameter int MSG_GAP   = 7
) (
  input  logic       clk,
  input  logic       rst,
  output logic       lamp,
  output logic [1:0] char_idx
);

  localparam int MAX_A = (SHORT_LEN > DASH_LEN) ? SHORT_LEN : DASH_LEN;
  localparam int MAX_B = (CHAR_GAP > MSG_GAP) ? CHAR_GAP : MSG_GAP;
  localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW    = $clog2(MAX_D) + 1;

  typedef enum logic [1:0] {D_SHORT, D_CHAR, D_DASH, D_MSG} dur_e;

  // shared reloadable timer
  logic [TW-1:0] tcount, tload_val;
  logic          tdone, tload;
  dur_e          tsel;

  always_comb begin
    case (tsel)
      D_SHORT: tload_val = TW'(SHORT_LEN - 1);
      D_CHAR:  tload_val = TW'(CHAR_GAP - 1);
      D_DASH:  tload_val = TW'(DASH_LEN - 1);
      default: tload_val = TW'(MSG_GAP - 1);
    endcase
  end

  assign tdone = (tcount == '0);
  assign tload = tdone;

  always_ff @(posedge clk) begin
    if (rst)        tcount <= TW'(SHORT_LEN - 1);
    else if (tload) tcount <= tload_val;
    else            tcount <= tcount - 1'b1;
  end

  // character FSM: three flashes plus trailing gaps
  logic       flash_on;
  logic [1:0] fcnt;
  logic [1:0] chr;
  logic       char_end, next_long;

  assign char_end  = tdone && !flash_on && (fcnt == 2'd2);
  assign next_long = (fcnt == 2'd2) ? (chr == 2'd0) : (chr == 2'd1);

  always_comb begin
    if (flash_on)
      tsel = (fcnt != 2'd2) ? D_SHORT : ((chr == 2'd2) ? D_MSG : D_CHAR);
    else
      tsel = next_long ? D_DASH : D_SHORT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flash_on <= 1'b1;
      fcnt     <= 2'd0;
    end else if (tdone) begin
      if (flash_on) flash_on <= 1'b0;
      else begin
        flash_on <= 1'b1;
        fcnt     <= (fcnt == 2'd2) ? 2'd0 : fcnt + 2'd1;
      end
    end
  end

  // SOS FSM: letter sequencing
  always_ff @(posedge clk) begin
    if (rst)           chr <= 2'd0;
    else if (char_end) chr <= (chr == 2'd2) ? 2'd0 : chr + 2'd1;
  end

  assign lamp     = flash_on & ~rst;
  assign char_idx = chr;

  assert_dot_len_R1: assert property (@(posedge clk) disable iff (rst)
    ($rose(lamp) && char_idx != 2'd1) |=> !lamp);

  assert_dash_min_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(lamp) && char_idx == 2'd1) |=> lamp);

  assert_char_step_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(char_idx) |-> (lamp && fcnt == 2'd0));

  assert_char_range_R3: assert property (@(posedge clk) disable iff (rst)
    char_idx != 2'd3);

  assert_elem_gap_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(lamp) && fcnt != 2'd2 && SHORT_LEN == 1) |=> lamp);

  assert_timer_step_R7: assert property (@(posedge clk) disable iff (rst)
    !tdone |=> (tcount == TW'($past(tcount) - 1'b1)));

endmodule

// File: tb/sos_beacon_test.sv
module sos_beacon_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 18;
  localparam int PERIOD = 37;

  localparam bit SEG_ON [NSEG] = '{1,0,1,0,1,0, 1,0,1,0,1,0, 1,0,1,0,1,0};
  localparam int SEG_LEN[NSEG] = '{1,1,1,1,1,3, 4,1,4,1,4,3, 1,1,1,1,1,7};
  localparam int SEG_CH [NSEG] = '{0,0,0,0,0,0, 1,1,1,1,1,1, 2,2,2,2,2,2};
  localparam string SEG_REQ[NSEG] = '{"R1","R4","R1","R4","R1","R5",
                                      "R2","R4","R2","R4","R2","R5",
                                      "R1","R4","R1","R4","R1","R6"};

  logic clk = 0, rst = 1;
  logic lamp;
  logic [1:0] char_idx;
  int checks = 0, fails = 0;
  bit done_flag = 0;

  sos_beacon uut (.clk(clk), .rst(rst), .lamp(lamp), .char_idx(char_idx));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", {1'b0, lamp}, 2'd0, "lamp in reset");
    chk("R8", char_idx, 2'd0, "char_idx in reset");
    rst = 0;
    for (int rep = 0; rep < 3; rep++) begin
      for (int s = 0; s < NSEG; s++) begin
        for (int k = 0; k < SEG_LEN[s]; k++) begin
          #1;
          chk(SEG_REQ[s], {1'b0, lamp}, {1'b0, SEG_ON[s]}, "lamp (R7 interval)");
          chk("R3", char_idx, 2'(SEG_CH[s]), "char_idx");
          @(negedge clk);
        end
      end
    end
    // reset in the middle of the second dash of O
    repeat (13) @(negedge clk);
    #1;
    chk("R2", {1'b0, lamp}, 2'd1, "lamp inside dash before reset");
    rst = 1;
    #1;
    chk("R8", {1'b0, lamp}, 2'd0, "lamp during mid-dash reset");
    @(negedge clk);
    #1;
    chk("R8", {1'b0, lamp}, 2'd0, "lamp held off in reset");
    chk("R8", char_idx, 2'd0, "char_idx after mid reset");
    rst = 0;
    #1;
    chk("R8", {1'b0, lamp}, 2'd1, "first dot right after release");
    @(negedge clk);
    #1;
    chk("R1", {1'b0, lamp}, 2'd0, "dot ends after one cycle");
    chk("R3", char_idx, 2'd0, "restart at first S");
    // period check: one full period later pattern returns to first dot
    repeat (PERIOD - 1) @(negedge clk);
    #1;
    chk("R6", {1'b0, lamp}, 2'd1, "period restart lamp");
    chk("R6", char_idx, 2'd0, "period restart char");
    done_flag = 1;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
    end
  end

  initial begin
    wait (done_flag || $time > 2000 * CLK_PERIOD);
    #(CLK_PERIOD);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule